// File: doc/BRIEF.md
# SATA Host Shadow Status Register

This block lives in a serial ATA host adapter. It keeps the emulated ATA status, error and device bytes that driver software reads, even though the real device is at the far end of a serial link. The receive path hands it decoded frame fields, and the block folds them into the shadow bytes. Each frame type changes only the status bits it actually carries. Busy and data-request are never touched by a set-device-bits frame. A PIO setup frame leaves an end-status value waiting, and that value takes effect when the PIO data block finishes.

Software side: a command write raises busy at once and starts a host-to-device register frame. That start is suppressed when the device-select bit names device 1, because a serial device always acts as device 0. While busy is set, software writes are dropped, apart from the device-reset command code. An interrupt-pending flag is raised by any frame that carries the interrupt bit. A software read of the status register clears it.

Top module: `sata_shadow_regs`

## Requirements
- R1: After reset the status byte is 0x80 (busy, bit 7), the error and device bytes are 0x00, and irq_pend_o and tx_en_o are 0.
- R2: Until the first device-to-host register frame (fis_kind=1) arrives, PIO setup (2) and set-device-bits (3) frames change no byte and the status byte stays 0x80.
- R3: A device-to-host register frame replaces the status, error and device bytes with fis_status, fis_error and fis_device in the next cycle, and discards any waiting end status.
- R4: A PIO setup frame loads status, error and device from its fields and stores fis_estatus. The first later pio_done cycle copies that end status into the status byte. A pio_done with no stored end status changes nothing.
- R5: A set-device-bits frame keeps status bits 7 (BSY) and 3 (DRQ). It takes every other status bit, bit 6 (DRDY) included, from fis_status, loads the error byte, and leaves the device byte as it was.
- R6: A software write to address 7 (command) while BSY=0 sets BSY in the next cycle and leaves the other status bits unchanged.
- R7: While BSY=1, software writes to address 6 (device) and address 7 are ignored, except a command write of code 0x08 (device reset), which is accepted.
- R8: An accepted command write gives a single-cycle tx_en_o pulse in the next cycle only if device byte bit 4 (DEV) is 0. The accepted code appears on cmd_o.
- R9: A frame with fis_irq=1 sets irq_pend_o. A software read of address 7 clears it. If both happen in the same cycle, the set wins.
- R10: A software write in a cycle in which a frame arrives (fis_kind not 0) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fis_kind | input | 2 | Frame strobe: 0 none, 1 device-to-host register, 2 PIO setup, 3 set device bits |
| fis_status | input | 8 | Status field of the frame |
| fis_error | input | 8 | Error field of the frame |
| fis_device | input | 8 | Device field of the frame |
| fis_estatus | input | 8 | End-status field (PIO setup only) |
| fis_irq | input | 1 | Interrupt bit of the frame |
| pio_done | input | 1 | PIO data block finished |
| sw_wr | input | 1 | Software register write strobe |
| sw_rd | input | 1 | Software register read strobe |
| sw_addr | input | 3 | Register address (6 device, 7 command/status) |
| sw_wdata | input | 8 | Write data |
| status_o | output | 8 | Shadow status byte |
| error_o | output | 8 | Shadow error byte |
| device_o | output | 8 | Shadow device byte |
| cmd_o | output | 8 | Last accepted command code |
| tx_en_o | output | 1 | Start a host-to-device register frame |
| irq_pend_o | output | 1 | Interrupt pending |

## Verification
Some rules are checked by the assertions on every cycle: the reset hold before the first register frame, the full overwrite by a register frame, the busy and data-request bits being kept across set-device-bits frames, busy following a command write, transmit never firing with DEV=1, and the interrupt being cleared by a status read. Other behaviours need the bench's ordered scenarios, because they depend on history. These include the deferred PIO end status and its single use, the device-reset exception while busy, the drop of a write that collides with a frame, and the rule that set beats clear on the interrupt flag.

// File: rtl/sata_shadow_pkg.sv
package sata_shadow_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_D2H  = 2'd1,
    FK_PIO  = 2'd2,
    FK_SDB  = 2'd3
  } fis_kind_e;

  localparam int BSY_POS  = 7;
  localparam int DRDY_POS = 6;
  localparam int DEV_POS  = 4;
  localparam int DRQ_POS  = 3;
endpackage

// File: rtl/shadow_status_unit.sv
module shadow_status_unit
  import sata_shadow_pkg::*;
#(
  parameter int           DW         = 8,
  parameter logic [DW-1:0] RST_STATUS = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fis_kind,
  input  logic [DW-1:0] fis_status,
  input  logic [DW-1:0] fis_error,
  input  logic [DW-1:0] fis_device,
  input  logic [DW-1:0] fis_estatus,
  input  logic          pio_done,
  input  logic          dev_wr,
  input  logic [DW-1:0] dev_wdata,
  input  logic          cmd_set_bsy,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] error_q,
  output logic [DW-1:0] device_q,
  output logic          seen_q
);
  // bits a set-device-bits frame must leave alone
  localparam logic [DW-1:0] SDB_KEEP = DW'((1 << BSY_POS) | (1 << DRQ_POS));

  logic [DW-1:0] status_d, error_d, device_d, pend_q, pend_d;
  logic          seen_d, pend_v_q, pend_v_d;
  logic [DW-1:0] sdb_merge;

  genvar gi;
  generate
    for (gi = 0; gi < DW; gi++) begin : g_sdb
      if (SDB_KEEP[gi]) begin : g_keep
        assign sdb_merge[gi] = status_q[gi];
      end else begin : g_take
        assign sdb_merge[gi] = fis_status[gi];
      end
    end
  endgenerate

  always_comb begin
    status_d = status_q;
    error_d  = error_q;
    device_d = device_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    seen_d   = seen_q;
    if (pio_done && pend_v_q) begin
      status_d = pend_q;
      pend_v_d = 1'b0;
    end
    unique case (fis_kind_e'(fis_kind))
      FK_D2H: begin
        status_d = fis_status;
        error_d  = fis_error;
        device_d = fis_device;
        pend_v_d = 1'b0;
        seen_d   = 1'b1;
      end
      FK_PIO: if (seen_q) begin
        status_d = fis_status;
        error_d  = fis_error;
        device_d = fis_device;
        pend_d   = fis_estatus;
        pend_v_d = 1'b1;
      end
      FK_SDB: if (seen_q) begin
        status_d = sdb_merge;
        error_d  = fis_error;
      end
      default: ;
    endcase
    if (dev_wr) device_d = dev_wdata;
    if (cmd_set_bsy) status_d[BSY_POS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= RST_STATUS;
      error_q  <= '0;
      device_q <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      error_q  <= error_d;
      device_q <= device_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      seen_q   <= seen_d;
    end
  end
endmodule

// File: rtl/shadow_sw_port.sv
module shadow_sw_port
  import sata_shadow_pkg::*;
#(
  parameter int                DW         = 8,
  parameter int                AW         = 3,
  parameter logic [AW-1:0]     ADDR_DEV   = 3'd6,
  parameter logic [AW-1:0]     ADDR_CMD   = 3'd7,
  parameter logic [DW-1:0]     DEVRST_CMD = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_wdata,
  input  logic          fis_busy_cycle,
  input  logic          bsy,
  input  logic          dev_sel,
  output logic          dev_wr,
  output logic          cmd_set_bsy,
  output logic          tx_en_q,
  output logic [DW-1:0] cmd_q
);
  logic          wr_ok, is_rst, cmd_acc, tx_d;
  logic [DW-1:0] cmd_d;

  always_comb begin
    wr_ok       = sw_wr && !fis_busy_cycle;
    is_rst      = (sw_wdata == DEVRST_CMD);
    dev_wr      = wr_ok && (sw_addr == ADDR_DEV) && !bsy;
    cmd_acc     = wr_ok && (sw_addr == ADDR_CMD) && (!bsy || is_rst);
    cmd_set_bsy = cmd_acc;
    tx_d        = cmd_acc && !dev_sel;
    cmd_d       = cmd_acc ? sw_wdata : cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      tx_en_q <= tx_d;
      cmd_q   <= cmd_d;
    end
  end
endmodule

// File: rtl/shadow_irq_unit.sv
module shadow_irq_unit #(
  parameter int            AW       = 3,
  parameter logic [AW-1:0] ADDR_CMD = 3'd7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fis_any,
  input  logic          fis_irq,
  input  logic          sw_rd,
  input  logic [AW-1:0] sw_addr,
  output logic          irq_q
);
  logic irq_d, set_c, clr_c;

  always_comb begin
    set_c = fis_any && fis_irq;
    clr_c = sw_rd && (sw_addr == ADDR_CMD);
    irq_d = set_c || (irq_q && !clr_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/sata_shadow_regs.sv
module sata_shadow_regs
  import sata_shadow_pkg::*;
#(
  parameter int            DW         = 8,
  parameter int            AW         = 3,
  parameter logic [AW-1:0] ADDR_DEV   = 3'd6,
  parameter logic [AW-1:0] ADDR_CMD   = 3'd7,
  parameter logic [DW-1:0] DEVRST_CMD = 8'h08,
  parameter logic [DW-1:0] RST_STATUS = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fis_kind,
  input  logic [DW-1:0] fis_status,
  input  logic [DW-1:0] fis_error,
  input  logic [DW-1:0] fis_device,
  input  logic [DW-1:0] fis_estatus,
  input  logic          fis_irq,
  input  logic          pio_done,
  input  logic          sw_wr,
  input  logic          sw_rd,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] error_o,
  output logic [DW-1:0] device_o,
  output logic [DW-1:0] cmd_o,
  output logic          tx_en_o,
  output logic          irq_pend_o
);
  logic fis_any, dev_wr, cmd_set_bsy, seen_w;

  assign fis_any = (fis_kind != 2'd0);

  shadow_status_unit #(.DW(DW), .RST_STATUS(RST_STATUS)) u_stat (
    .clk, .rst_n, .fis_kind, .fis_status, .fis_error, .fis_device,
    .fis_estatus, .pio_done, .dev_wr, .dev_wdata(sw_wdata), .cmd_set_bsy,
    .status_q(status_o), .error_q(error_o), .device_q(device_o),
    .seen_q(seen_w)
  );

  shadow_sw_port #(.DW(DW), .AW(AW), .ADDR_DEV(ADDR_DEV), .ADDR_CMD(ADDR_CMD),
                   .DEVRST_CMD(DEVRST_CMD)) u_sw (
    .clk, .rst_n, .sw_wr, .sw_addr, .sw_wdata, .fis_busy_cycle(fis_any),
    .bsy(status_o[BSY_POS]), .dev_sel(device_o[DEV_POS]), .dev_wr,
    .cmd_set_bsy, .tx_en_q(tx_en_o), .cmd_q(cmd_o)
  );

  shadow_irq_unit #(.AW(AW), .ADDR_CMD(ADDR_CMD)) u_irq (
    .clk, .rst_n, .fis_any, .fis_irq, .sw_rd, .sw_addr, .irq_q(irq_pend_o)
  );
endmodule

// File: rtl/shadow_regs_chk.sv
module shadow_regs_chk #(
  parameter int            DW         = 8,
  parameter int            AW         = 3,
  parameter logic [AW-1:0] ADDR_CMD   = 3'd7,
  parameter logic [DW-1:0] RST_STATUS = 8'h80
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    fis_kind,
  input logic [DW-1:0] fis_status,
  input logic [DW-1:0] fis_error,
  input logic [DW-1:0] fis_device,
  input logic          fis_irq,
  input logic          pio_done,
  input logic          sw_wr,
  input logic          sw_rd,
  input logic [AW-1:0] sw_addr,
  input logic [DW-1:0] status_o,
  input logic [DW-1:0] error_o,
  input logic [DW-1:0] device_o,
  input logic          tx_en_o,
  input logic          irq_pend_o,
  input logic          seen
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> status_o == RST_STATUS);

  p_d2h_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fis_kind == 2'd1) |=> (status_o == $past(fis_status)) &&
      (error_o == $past(fis_error)) && (device_o == $past(fis_device)));

  p_sdb_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fis_kind == 2'd3 && !pio_done) |=>
      (status_o[7] == $past(status_o[7])) && (status_o[3] == $past(status_o[3])));

  p_cmd_bsy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_addr == ADDR_CMD && fis_kind == 2'd0 && !status_o[7]) |=> status_o[7]);

  p_tx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> !device_o[4]);

  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && sw_addr == ADDR_CMD && !(fis_kind != 2'd0 && fis_irq)) |=> !irq_pend_o);
endmodule

bind sata_shadow_regs shadow_regs_chk #(
  .DW(DW), .AW(AW), .ADDR_CMD(ADDR_CMD), .RST_STATUS(RST_STATUS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fis_kind(fis_kind), .fis_status(fis_status),
  .fis_error(fis_error), .fis_device(fis_device), .fis_irq(fis_irq),
  .pio_done(pio_done), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_addr(sw_addr),
  .status_o(status_o), .error_o(error_o), .device_o(device_o),
  .tx_en_o(tx_en_o), .irq_pend_o(irq_pend_o), .seen(seen_w)
);

// File: tb/sim_sata_shadow_regs.sv
module sim_sata_shadow_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] fis_kind;
  logic [7:0] fis_status, fis_error, fis_device, fis_estatus;
  logic       fis_irq, pio_done, sw_wr, sw_rd;
  logic [2:0] sw_addr;
  logic [7:0] sw_wdata;
  logic [7:0] status_o, error_o, device_o, cmd_o;
  logic       tx_en_o, irq_pend_o;

  always #10 clk = ~clk;

  sata_shadow_regs u0 (.*);

  typedef struct {
    logic [7:0] st, er, dv;
    logic       irq, tx;
    string      tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cycles = 0;
  bit done_flag = 0;

  // reference state built from the requirements
  logic [7:0] m_st, m_er, m_dv, m_pend;
  logic       m_seen, m_pv, m_irq;

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (status_o !== e.st || error_o !== e.er || device_o !== e.dv ||
          irq_pend_o !== e.irq || tx_en_o !== e.tx) begin
        fails++;
        $display("FAIL %s: got st=%h er=%h dv=%h irq=%b tx=%b exp st=%h er=%h dv=%h irq=%b tx=%b",
                 e.tag, status_o, error_o, device_o, irq_pend_o, tx_en_o,
                 e.st, e.er, e.dv, e.irq, e.tx);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic idle_inputs();
    fis_kind = 0; fis_status = 0; fis_error = 0; fis_device = 0; fis_estatus = 0;
    fis_irq = 0; pio_done = 0; sw_wr = 0; sw_rd = 0; sw_addr = 0; sw_wdata = 0;
  endtask

  task automatic step(input logic [1:0] k, input logic [7:0] s, input logic [7:0] e,
                      input logic [7:0] d, input logic [7:0] es, input logic irq,
                      input logic dn, input logic wr, input logic rd,
                      input logic [2:0] a, input logic [7:0] wd, input string tag);
    exp_t x;
    logic bsy, fisv, wr_ok, dev_w, cmd_acc, tx;
    @(negedge clk);
    fis_kind = k; fis_status = s; fis_error = e; fis_device = d; fis_estatus = es;
    fis_irq = irq; pio_done = dn; sw_wr = wr; sw_rd = rd; sw_addr = a; sw_wdata = wd;
    bsy = m_st[7]; fisv = (k != 0);
    wr_ok = wr && !fisv;                                   // R10
    dev_w = wr_ok && a == 3'd6 && !bsy;                    // R7
    cmd_acc = wr_ok && a == 3'd7 && (!bsy || wd == 8'h08); // R6 R7
    tx = cmd_acc && !m_dv[4];                              // R8
    if (dn && m_pv) begin m_st = m_pend; m_pv = 0; end     // R4
    case (k)
      2'd1: begin m_st = s; m_er = e; m_dv = d; m_pv = 0; m_seen = 1; end
      2'd2: if (m_seen) begin m_st = s; m_er = e; m_dv = d; m_pend = es; m_pv = 1; end
      2'd3: if (m_seen) begin m_st = (m_st & 8'h88) | (s & 8'h77); m_er = e; end
      default: ;
    endcase
    if (dev_w) m_dv = wd;
    if (cmd_acc) m_st[7] = 1'b1;
    m_irq = (fisv && irq) || (m_irq && !(rd && a == 3'd7)); // R9
    @(negedge clk);
    idle_inputs();
    x.st = m_st; x.er = m_er; x.dv = m_dv; x.irq = m_irq; x.tx = tx; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic fis(input logic [1:0] k, input logic [7:0] s, input logic [7:0] e,
                     input logic [7:0] d, input logic [7:0] es, input logic irq, input string tag);
    step(k, s, e, d, es, irq, 0, 0, 0, 3'd0, 8'h00, tag);
  endtask

  task automatic swr(input logic [2:0] a, input logic [7:0] wd, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, a, wd, tag);
  endtask

  initial begin
    exp_t r;
    idle_inputs();
    rst_n = 0;
    m_st = 8'h80; m_er = 0; m_dv = 0; m_pend = 0; m_seen = 0; m_pv = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    r.st = 8'h80; r.er = 0; r.dv = 0; r.irq = 0; r.tx = 0; r.tag = "R1";
    q.push_back(r);

    fis(2'd3, 8'h41, 8'h04, 8'h00, 8'h00, 0, "R2 sdb before d2h");
    fis(2'd2, 8'h58, 8'h00, 8'h00, 8'h50, 0, "R2 pio before d2h");
    swr(3'd7, 8'h25, "R7 cmd while busy");
    swr(3'd6, 8'h10, "R7 dev while busy");
    fis(2'd1, 8'h50, 8'h00, 8'hA0, 8'h00, 1, "R3 d2h load");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd7, 0, "R9 status read clears");
    swr(3'd6, 8'h10, "R7 dev write when idle");
    swr(3'd7, 8'h25, "R8 gated by DEV=1");
    fis(2'd1, 8'h50, 8'h01, 8'hA0, 8'h00, 0, "R3 d2h clears busy");
    swr(3'd7, 8'hC8, "R6 cmd sets bsy R8 tx");
    swr(3'd7, 8'h20, "R7 cmd dropped while busy");
    swr(3'd7, 8'h08, "R7 device reset accepted");
    fis(2'd1, 8'h50, 8'h00, 8'h40, 8'h00, 0, "R3 d2h");
    fis(2'd2, 8'h58, 8'h00, 8'h40, 8'h50, 0, "R4 pio setup");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 3'd0, 0, "R4 pio done applies");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 3'd0, 0, "R4 done without pending");
    fis(2'd3, 8'h89, 8'h04, 8'hFF, 8'h00, 0, "R5 sdb drdy clear");
    fis(2'd3, 8'h40, 8'h00, 8'h00, 8'h00, 1, "R5 sdb drdy set");
    step(2'd1, 8'h50, 8'h00, 8'h40, 0, 1, 0, 0, 1, 3'd7, 0, "R9 set wins");
    step(2'd1, 8'h50, 8'h00, 8'h40, 0, 0, 0, 1, 0, 3'd7, 8'hC8, "R10 write dropped");
    fis(2'd1, 8'hD8, 8'h00, 8'h40, 8'h00, 0, "R3 busy drq");
    fis(2'd3, 8'h77, 8'h00, 8'h00, 8'h00, 0, "R5 keep bsy drq");
    @(negedge clk);
    @(negedge clk);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule